// File: doc/BRIEF.md
# Inbound Mailbox Register Queue

This block carries 32-bit messages from a coprocessor to a host CPU. The coprocessor places words into a shallow first-in first-out queue through a one-cycle push port. The host reaches the queue through a simple 32-bit register port addressed by byte offset. Reading the pop window removes the oldest word, and a separate peek register shows that word without removing it. A status register reports full, empty and the current fill level. A config register holds an enable for a level interrupt that stays asserted while data is waiting.

The queue is held as a shift register. Slot 0 is always the head. After a pop the remaining words move one slot toward the head, and every slot above the fill level holds a fixed invalid-data marker. Reading an empty queue returns that marker and leaves the queue unchanged. Only the low eight bits of the bus offset are decoded.

Top module: `inbox_mailbox`

## Requirements
- R1: A read at any word-aligned offset 0x80, 0x84, 0x88 or 0x8C (low 8 address bits only; upper bits ignored) returns the head word and removes it. On an empty queue it returns the invalid marker (default 32'hFFFF_FFFF) and the queue stays empty.
- R2: A read at offset 0x90 returns the head word without removing it, or the invalid marker when the queue is empty.
- R3: The status register at offset 0x98 has bit 31 set when the fill level equals the depth, bit 30 set when the level is zero, the level in bits 7:0, and all other bits zero. Bits 31 and 30 are never both set.
- R4: The config register at offset 0x9C reads bit 0 as the data-interrupt enable and bit 4 as the data-pending flag, which is 1 exactly when the queue is not empty. All other bits read 0.
- R5: The interrupt output is 1 only when the enable bit is 1 and the queue is not empty.
- R6: A write to offset 0x9C loads bit 0 of the write data into the enable and changes nothing else.
- R7: After reset the level is 0, the enable is 0, the interrupt output is 0, and peek returns the invalid marker.
- R8: Words leave in the order they were pushed. After a pop, the vacated top slot holds the invalid marker, so peek on a queue just emptied returns the marker.
- R9: A push while the queue is full and no pop happens in the same cycle is dropped. The level stays at the depth and the stored words are unchanged.
- R10: The offset 0x94 reads as zero. Reads at undefined offsets return zero. Writes to 0x94, to the pop window or to undefined offsets change no state.
- R11: A push and a pop in the same cycle both take effect. The pop returns the old head, the level is unchanged, and on a full queue the new word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset; only bits 7:0 decoded |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| push_valid | input | 1 | Coprocessor push strobe |
| push_data | input | 32 | Word to enqueue |
| irq | output | 1 | Level interrupt: data waiting and enabled |

## Verification
The coprocessor push and the host pop can land in the same cycle. Both then update the shift register, and the push targets the slot that the shift has just freed. The bench drives a push and a pop-window read together, once on a partly filled queue and once on a full queue. It then judges the returned word, the level in the status register, and the order of the words drained afterwards, so a lost, duplicated or misplaced word is detected.

// File: rtl/inbox_pkg.sv
package inbox_pkg;

    localparam logic [7:0] OFF_POP_BASE = 8'h80;
    localparam logic [7:0] OFF_PEEK     = 8'h90;
    localparam logic [7:0] OFF_SENDER   = 8'h94;
    localparam logic [7:0] OFF_STATUS   = 8'h98;
    localparam logic [7:0] OFF_CONFIG   = 8'h9C;

    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_PEND_BIT   = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POP,
        SEL_PEEK,
        SEL_ZERO,
        SEL_STATUS,
        SEL_CONFIG
    } reg_sel_e;

    typedef struct packed {
        logic full;
        logic empty;
    } q_flags_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        reg_sel_e s;
        s = SEL_NONE;
        if (off[7:4] == OFF_POP_BASE[7:4] && off[1:0] == 2'b00)
            s = SEL_POP;
        else if (off == OFF_PEEK)
            s = SEL_PEEK;
        else if (off == OFF_SENDER)
            s = SEL_ZERO;
        else if (off == OFF_STATUS)
            s = SEL_STATUS;
        else if (off == OFF_CONFIG)
            s = SEL_CONFIG;
        return s;
    endfunction

endpackage

// File: rtl/inbox_queue.sv
module inbox_queue
    import inbox_pkg::*;
#(
    parameter int              DEPTH   = 8,
    parameter int              DATA_W  = 32,
    parameter logic [DATA_W-1:0] INVALID = '1,
    parameter int              CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output q_flags_t          flags_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DATA_W-1:0] slot_d [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W-1:0]  wr_idx;
    logic              pop_eff;
    logic              push_ok;

    assign flags_o.empty = (cnt_q == '0);
    assign flags_o.full  = (cnt_q == DEPTH_C);
    assign pop_eff       = pop_i && !flags_o.empty;
    assign push_ok       = push_i && (!flags_o.full || pop_eff);
    assign wr_idx        = pop_eff ? cnt_q - 1'b1 : cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok && !pop_eff)
            cnt_d = cnt_q + 1'b1;
        else if (pop_eff && !push_ok)
            cnt_d = cnt_q - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] shifted;
        if (i == DEPTH - 1) begin : g_top
            assign shifted = INVALID;
        end else begin : g_mid
            assign shifted = slot_q[i+1];
        end

        always_comb begin
            slot_d[i] = pop_eff ? shifted : slot_q[i];
            if (push_ok && wr_idx == CNT_W'(i))
                slot_d[i] = push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int k = 0; k < DEPTH; k++)
                slot_q[k] <= INVALID;
        end else begin
            cnt_q <= cnt_d;
            for (int k = 0; k < DEPTH; k++)
                slot_q[k] <= slot_d[k];
        end
    end

    assign head_o  = slot_q[0];
    assign count_o = cnt_q;

    // R9: a push into a full queue without a pop leaves it full
    a_r9_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (flags_o.full && push_i && !pop_i) |=> (cnt_q == DEPTH_C && $stable(slot_q[0])));

    // R8: the top slot is refilled with the marker whenever it is unused
    a_r8_top_refill: assert property (@(posedge clk) disable iff (rst)
        !flags_o.full |-> (slot_q[DEPTH-1] == INVALID));

    // R1: popping an empty queue without a push keeps it empty
    a_r1_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
        (flags_o.empty && pop_i && !push_i) |=> (cnt_q == '0));

    // R11: simultaneous pop and push on a non-empty queue keep the level
    a_r11_level_kept: assert property (@(posedge clk) disable iff (rst)
        (!flags_o.empty && pop_i && push_i) |=> $stable(cnt_q));

    // R7: reset empties the queue
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && slot_q[0] == INVALID));

endmodule

// File: rtl/inbox_regs.sv
module inbox_regs
    import inbox_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter logic [DATA_W-1:0] INVALID = '1,
    parameter int              CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        off_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] head_i,
    input  logic [CNT_W-1:0]  count_i,
    input  q_flags_t          flags_i,
    output logic              pop_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    reg_sel_e          sel;
    logic              en_q;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] config_w;
    logic              pending;

    assign sel     = decode_offset(off_i);
    assign pending = !flags_i.empty;
    assign pop_o   = rd_i && (sel == SEL_POP);

    always_comb begin
        status_w                 = '0;
        status_w[7:0]            = 8'(count_i);
        status_w[STAT_FULL_BIT]  = flags_i.full;
        status_w[STAT_EMPTY_BIT] = flags_i.empty;
    end

    always_comb begin
        config_w               = '0;
        config_w[CFG_EN_BIT]   = en_q;
        config_w[CFG_PEND_BIT] = pending;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (sel)
                SEL_POP:    rdata_o = flags_i.empty ? INVALID : head_i;
                SEL_PEEK:   rdata_o = head_i;
                SEL_STATUS: rdata_o = status_w;
                SEL_CONFIG: rdata_o = config_w;
                default:    rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (wr_i && sel == SEL_CONFIG)
            en_q <= wdata_i[CFG_EN_BIT];
    end

    assign irq_o = en_q && pending;

    // R6: a config write loads the enable from write-data bit 0
    a_r6_cfg_write: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_CONFIG) |=> (en_q == $past(wdata_i[CFG_EN_BIT])));

    // R6: the enable changes only through a config write
    a_r6_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && sel == SEL_CONFIG) |=> $stable(en_q));

    // R3: full and empty are never reported together
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flags_i.full && flags_i.empty));

    // R5: the interrupt never fires without waiting data
    a_r5_irq_needs_data: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (count_i != '0));

endmodule

// File: rtl/inbox_mailbox.sv
module inbox_mailbox
    import inbox_pkg::*;
#(
    parameter int          DEPTH   = 8,
    parameter int          ADDR_W  = 12,
    parameter logic [31:0] INVALID = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              push_valid,
    input  logic [31:0]       push_data,
    output logic              irq
);

    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  count;
    q_flags_t          flags;
    logic              pop;

    inbox_queue #(
        .DEPTH   (DEPTH),
        .DATA_W  (DATA_W),
        .INVALID (INVALID),
        .CNT_W   (CNT_W)
    ) u_queue (
        .clk         (clk),
        .rst         (rst),
        .pop_i       (pop),
        .push_i      (push_valid),
        .push_data_i (push_data),
        .head_o      (head),
        .count_o     (count),
        .flags_o     (flags)
    );

    inbox_regs #(
        .DATA_W  (DATA_W),
        .INVALID (INVALID),
        .CNT_W   (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .off_i   (bus_addr[7:0]),
        .rd_i    (bus_rd),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .head_i  (head),
        .count_i (count),
        .flags_i (flags),
        .pop_o   (pop),
        .rdata_o (bus_rdata),
        .irq_o   (irq)
    );

endmodule

// File: tb/inbox_mailbox_bench.sv
`timescale 1ns/1ps
module inbox_mailbox_bench;

    localparam int          DEPTH = 8;
    localparam logic [31:0] INV   = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    inbox_mailbox #(.DEPTH(DEPTH)) u_inbox_mailbox (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .push_valid(push_valid), .push_data(push_data), .irq(irq)
    );

    function automatic logic [31:0] stat_of(input int n);
        logic [31:0] s;
        s = '0;
        s[7:0] = 8'(n);
        s[31]  = (n == DEPTH);
        s[30]  = (n == 0);
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push(input logic [31:0] v);
        push_valid = 1'b1; push_data = v;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic push_pop(input logic [31:0] v, output logic [31:0] d);
        push_valid = 1'b1; push_data = v;
        bus_rd = 1'b1; bus_addr = 12'h080;
        #1 d = bus_rdata;
        @(negedge clk);
        push_valid = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        rd(12'h098, d); check("R7 status after reset", d, stat_of(0));
        rd(12'h09C, d); check("R7 config after reset", d, 32'h0);
        check("R7 irq after reset", {31'b0, irq}, 32'h0);
        rd(12'h090, d); check("R7 peek after reset", d, INV);
        rd(12'h084, d); check("R1 pop of empty", d, INV);
        rd(12'h098, d); check("R1 empty after empty pop", d, stat_of(0));
    endtask

    task automatic t_order();
        logic [31:0] d;
        do_reset();
        push(32'hA1); push(32'hA2); push(32'hA3);
        rd(12'h098, d); check("R3 partial status", d, stat_of(3));
        rd(12'h090, d); check("R2 peek head", d, 32'hA1);
        rd(12'h098, d); check("R2 peek keeps level", d, stat_of(3));
        rd(12'h084, d); check("R8 first out", d, 32'hA1);
        rd(12'h08C, d); check("R8 second out", d, 32'hA2);
        rd(12'h188, d); check("R1 upper address bits ignored", d, 32'hA3);
        rd(12'h090, d); check("R8 peek after drain", d, INV);
        rd(12'h080, d); check("R1 pop after drain", d, INV);
    endtask

    task automatic t_full_drop();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(32'h100 + i);
        rd(12'h098, d); check("R3 full status", d, stat_of(DEPTH));
        push(32'hDEAD);
        rd(12'h098, d); check("R9 still full", d, stat_of(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            rd(12'h080, d); check("R9 drain order", d, 32'h100 + i);
        end
        rd(12'h098, d); check("R9 dropped word absent", d, stat_of(0));
    endtask

    task automatic t_irq_config();
        logic [31:0] d;
        do_reset();
        push(32'h55);
        rd(12'h09C, d); check("R4 pending without enable", d, 32'h10);
        check("R5 irq off when disabled", {31'b0, irq}, 32'h0);
        wr(12'h09C, 32'hFFFF_FFFF);
        rd(12'h09C, d); check("R6 only bit0 written", d, 32'h11);
        check("R5 irq on", {31'b0, irq}, 32'h1);
        rd(12'h080, d); check("R5 popped word", d, 32'h55);
        check("R5 irq off when empty", {31'b0, irq}, 32'h0);
        rd(12'h09C, d); check("R4 pending cleared", d, 32'h01);
        wr(12'h09C, 32'hFFFF_FFFE);
        rd(12'h09C, d); check("R6 enable cleared", d, 32'h00);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        do_reset();
        push(32'h77);
        wr(12'h094, 32'h1); wr(12'h080, 32'h1234); wr(12'h0A0, 32'h1); wr(12'h09D, 32'h1);
        rd(12'h098, d); check("R10 writes leave level", d, stat_of(1));
        rd(12'h09C, d); check("R10 writes leave config", d, 32'h10);
        rd(12'h094, d); check("R10 sender reads zero", d, 32'h0);
        rd(12'h0A0, d); check("R10 undefined reads zero", d, 32'h0);
        rd(12'h082, d); check("R10 misaligned reads zero", d, 32'h0);
        rd(12'h090, d); check("R10 head intact", d, 32'h77);
    endtask

    task automatic t_concurrent();
        logic [31:0] d;
        do_reset();
        push(32'hB1); push(32'hB2);
        push_pop(32'hB3, d); check("R11 pop returns old head", d, 32'hB1);
        rd(12'h098, d); check("R11 level unchanged", d, stat_of(2));
        rd(12'h080, d); check("R11 order after overlap", d, 32'hB2);
        rd(12'h080, d); check("R11 pushed word last", d, 32'hB3);
        for (int i = 0; i < DEPTH; i++) push(32'h200 + i);
        push_pop(32'hCC, d); check("R11 full overlap pop", d, 32'h200);
        rd(12'h098, d); check("R11 full overlap level", d, stat_of(DEPTH));
        for (int i = 1; i < DEPTH; i++) begin
            rd(12'h080, d); check("R11 full overlap drain", d, 32'h200 + i);
        end
        rd(12'h080, d); check("R11 full overlap new word", d, 32'hCC);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_order();
        t_full_drop();
        t_irq_config();
        t_ignored();
        t_concurrent();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule